// File: doc/BRIEF.md
# DRAM Absolute-Mode Address Multiplexer and Word Sequencer

This block moves one wide data word to or from a DRAM whose data bus is narrower than the word. A single start pulse brings a direction flag, a base word address and, for writes, the word to be stored. The block then runs one complete, independent DRAM access for each data segment. Every access has its own row strobe, column strobe and full precharge, and no open row is reused. The segments go from least to most significant. A read collects the segments into the word, and a write hands them out one at a time.

Each word address is split across a narrow multiplexed address bus. The row takes the low-order address bits and the column takes the next group of bits above them. A 4-bit mode value chooses the split width. Transfers are accepted only when the two upper mode bits are both set. The two lower bits then select a bus width of 8, 9, 10 or 11 pins. After each access the address can be post-incremented, so that the segments of a word land at consecutive addresses. Reads and writes each have their own enable for this.

With the default parameters the word is 24 bits and the data bus is 8 bits, so a word takes three accesses. Each phase of an access (row, column, data, precharge) lasts a programmable number of cycles.

Top module: `dram_abs_seq`

## Requirements
- R1: A start pulse is accepted only while the block is idle and mode[3:2] = 2'b11. Otherwise it has no effect: busy stays 0 and the strobes stay high.
- R2: In the row phase, ras_n = 0, cas_n = 1 and ma carries address bits [W-1:0], where W = 8 + mode[1:0]. So mode 1100 gives W = 8, 1101 gives 9, 1110 gives 10 and 1111 gives 11.
- R3: In the column and data phases, ma carries address bits [2W-1:W]. Pins of ma at or above W are 0, and address bits at or above 2W never reach ma.
- R4: Every access runs row, column, data and precharge in that order. ras_n and cas_n are both low in the column and data phases. Both are high in the precharge phase, which ends every access, including the last one.
- R5: The row, column, data and precharge phases last t_row, t_col, t_data and t_pre cycles. A value of 0 counts as 1.
- R6: A word takes NUM_SEG accesses (3 by default), least significant segment first. For a write, access k drives wdata[8k+7:8k] on dq_out with dq_oe = 1 and we_n = 0 during its column and data phases.
- R7: For a read, dq_in is sampled in the last data-phase cycle of access k and stored in rdata[8k+7:8k]. A write leaves rdata unchanged.
- R8: After each access the working address gains 1 (modulo 2^22) when the enable for the current direction is 1 (inc_rd for reads, inc_wr for writes). Otherwise it stays the same. next_base shows the working address, which is base + NUM_SEG or base after the word.
- R9: busy is high from the cycle after an accepted start through the last precharge cycle. done pulses for one cycle right after that, with busy low. A start, or any change of mode, timing, enables, base, wr or wdata, while busy has no effect on the transfer in progress.
- R10: When no access is in progress (idle or precharge), ma = 0, we_n = 1 and dq_oe = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode | input | 4 | Addressing mode; [3:2] must be 2'b11, [1:0] selects row width |
| inc_rd | input | 1 | Post-increment enable for reads |
| inc_wr | input | 1 | Post-increment enable for writes |
| t_row | input | 4 | Row phase length in cycles |
| t_col | input | 4 | Column phase length in cycles |
| t_data | input | 4 | Data phase length in cycles |
| t_pre | input | 4 | Precharge phase length in cycles |
| start | input | 1 | One-cycle request pulse |
| wr | input | 1 | 1 = write, 0 = read |
| base | input | 22 | Base word address |
| wdata | input | 24 | Word to write |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 24 | Packed read word |
| next_base | output | 22 | Working address after post-increments |
| ma | output | 11 | Multiplexed DRAM address |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| dq_out | output | 8 | Write data segment |
| dq_oe | output | 1 | Data bus output enable |
| dq_in | input | 8 | Read data segment |

## Verification
A wrong phase or counter state appears at the strobes in the very cycle it occurs. It shows as a phase that is too long or too short, or as a precharge that is missing. A bad segment index or packing shift shows up at once on dq_out for writes. For reads it stays hidden until done, when rdata holds a segment in the wrong lane. A wrong address increment shows on ma at the next row phase, and on next_base at done. The bench replays each word against a cycle list built from the requirements and compares every output on every clock. A divergence is therefore caught in the first cycle it reaches a pin.

// File: rtl/dram_abs_pkg.sv
package dram_abs_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_ROW  = 3'd1,
    PH_COL  = 3'd2,
    PH_DATA = 3'd3,
    PH_PRE  = 3'd4
  } phase_t;
endpackage

// File: rtl/dram_addr_split.sv
module dram_addr_split #(
  parameter int BASE_RW = 8,
  parameter int SEL_W   = 2,
  localparam int NUM_WIDTHS = 1 << SEL_W,
  localparam int MA_W       = BASE_RW + NUM_WIDTHS - 1,
  localparam int ADDR_W     = 2 * MA_W
) (
  input  logic [SEL_W-1:0]  width_sel,
  input  logic [ADDR_W-1:0] addr,
  output logic [MA_W-1:0]   row,
  output logic [MA_W-1:0]   col
);
  logic [MA_W-1:0] rows [NUM_WIDTHS];
  logic [MA_W-1:0] cols [NUM_WIDTHS];

  // One split per selectable width; low bits form the row, the next group the column.
  for (genvar g = 0; g < NUM_WIDTHS; g++) begin : g_width
    localparam int RW = BASE_RW + g;
    always_comb begin
      rows[g] = '0;
      cols[g] = '0;
      rows[g][RW-1:0] = addr[RW-1:0];
      cols[g][RW-1:0] = addr[2*RW-1:RW];
    end
  end

  assign row = rows[width_sel];
  assign col = cols[width_sel];
endmodule

// File: rtl/dram_phase_seq.sv
module dram_phase_seq
  import dram_abs_pkg::*;
#(
  parameter int NUM_SEG = 3,
  parameter int TIME_W  = 4,
  localparam int SEG_CNT_W = $clog2(NUM_SEG + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 go,
  input  logic [TIME_W-1:0]    t_row,
  input  logic [TIME_W-1:0]    t_col,
  input  logic [TIME_W-1:0]    t_data,
  input  logic [TIME_W-1:0]    t_pre,
  output phase_t               phase,
  output logic                 capture,
  output logic                 step_end,
  output logic                 done
);
  phase_t                phase_q, phase_d;
  logic [TIME_W-1:0]     cnt_q, cnt_d;
  logic [SEG_CNT_W-1:0]  seg_q, seg_d;
  logic                  done_q, done_d;
  logic [TIME_W-1:0]     row_len_q, col_len_q, data_len_q, pre_len_q;
  logic                  last_cyc;

  // Remaining-cycle load value; a zero length is treated as one cycle.
  function automatic logic [TIME_W-1:0] load_of(input logic [TIME_W-1:0] t);
    return (t == '0) ? '0 : t - 1'b1;
  endfunction

  assign last_cyc = (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    seg_d   = seg_q;
    done_d  = 1'b0;
    if (phase_q != PH_IDLE && !last_cyc) begin
      cnt_d = cnt_q - 1'b1;
    end
    unique case (phase_q)
      PH_IDLE: begin
        if (go) begin
          phase_d = PH_ROW;
          cnt_d   = load_of(t_row);
          seg_d   = '0;
        end
      end
      PH_ROW: begin
        if (last_cyc) begin
          phase_d = PH_COL;
          cnt_d   = load_of(col_len_q);
        end
      end
      PH_COL: begin
        if (last_cyc) begin
          phase_d = PH_DATA;
          cnt_d   = load_of(data_len_q);
        end
      end
      PH_DATA: begin
        if (last_cyc) begin
          phase_d = PH_PRE;
          cnt_d   = load_of(pre_len_q);
        end
      end
      PH_PRE: begin
        if (last_cyc) begin
          if (seg_q == SEG_CNT_W'(NUM_SEG - 1)) begin
            phase_d = PH_IDLE;
            done_d  = 1'b1;
          end else begin
            phase_d = PH_ROW;
            cnt_d   = load_of(row_len_q);
            seg_d   = seg_q + 1'b1;
          end
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q    <= PH_IDLE;
      cnt_q      <= '0;
      seg_q      <= '0;
      done_q     <= 1'b0;
      row_len_q  <= '0;
      col_len_q  <= '0;
      data_len_q <= '0;
      pre_len_q  <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      seg_q   <= seg_d;
      done_q  <= done_d;
      if (go) begin
        row_len_q  <= t_row;
        col_len_q  <= t_col;
        data_len_q <= t_data;
        pre_len_q  <= t_pre;
      end
    end
  end

  assign phase    = phase_q;
  assign capture  = (phase_q == PH_DATA) && last_cyc;
  assign step_end = (phase_q == PH_PRE) && last_cyc;
  assign done     = done_q;
endmodule

// File: rtl/dram_seg_pack.sv
module dram_seg_pack #(
  parameter int SEG_W   = 8,
  parameter int NUM_SEG = 3,
  localparam int WORD_W = SEG_W * NUM_SEG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] wdata,
  input  logic              advance,
  input  logic              capture,
  input  logic [SEG_W-1:0]  dq_in,
  output logic [SEG_W-1:0]  seg_out,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] wbuf_q, wbuf_d;
  logic [WORD_W-1:0] rbuf_q, rbuf_d;

  always_comb begin
    wbuf_d = wbuf_q;
    if (load) begin
      wbuf_d = wdata;
    end else if (advance) begin
      wbuf_d = wbuf_q >> SEG_W;   // next more significant segment moves down
    end
  end

  always_comb begin
    rbuf_d = rbuf_q;
    if (capture) begin
      rbuf_d = {dq_in, rbuf_q[WORD_W-1:SEG_W]};  // first segment ends at the bottom
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbuf_q <= '0;
      rbuf_q <= '0;
    end else begin
      wbuf_q <= wbuf_d;
      rbuf_q <= rbuf_d;
    end
  end

  assign seg_out = wbuf_q[SEG_W-1:0];
  assign rdata   = rbuf_q;
endmodule

// File: rtl/dram_abs_seq.sv
module dram_abs_seq
  import dram_abs_pkg::*;
#(
  parameter int SEG_W   = 8,
  parameter int NUM_SEG = 3,
  parameter int BASE_RW = 8,
  parameter int SEL_W   = 2,
  parameter int TIME_W  = 4,
  localparam int MODE_W = SEL_W + 2,
  localparam int MA_W   = BASE_RW + (1 << SEL_W) - 1,
  localparam int ADDR_W = 2 * MA_W,
  localparam int WORD_W = SEG_W * NUM_SEG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  logic              inc_rd,
  input  logic              inc_wr,
  input  logic [TIME_W-1:0] t_row,
  input  logic [TIME_W-1:0] t_col,
  input  logic [TIME_W-1:0] t_data,
  input  logic [TIME_W-1:0] t_pre,
  input  logic              start,
  input  logic              wr,
  input  logic [ADDR_W-1:0] base,
  input  logic [WORD_W-1:0] wdata,
  output logic              busy,
  output logic              done,
  output logic [WORD_W-1:0] rdata,
  output logic [ADDR_W-1:0] next_base,
  output logic [MA_W-1:0]   ma,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [SEG_W-1:0]  dq_out,
  output logic              dq_oe,
  input  logic [SEG_W-1:0]  dq_in
);
  // Reset: asserts at once, releases after two clock edges.
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  phase_t             phase;
  logic               capture, step_end, go, abs_mode, in_cas, in_access;
  logic [SEL_W-1:0]   sel_q;
  logic               wr_q, inc_q;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [MA_W-1:0]    row_a, col_a;
  logic [SEG_W-1:0]   seg_out;

  assign abs_mode = &mode[MODE_W-1:SEL_W];
  assign go       = start && abs_mode && (phase == PH_IDLE);

  always_comb begin
    addr_d = addr_q;
    if (go) begin
      addr_d = base;
    end else if (step_end && inc_q) begin
      addr_d = addr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q  <= '0;
      wr_q   <= 1'b0;
      inc_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      addr_q <= addr_d;
      if (go) begin
        sel_q <= mode[SEL_W-1:0];
        wr_q  <= wr;
        inc_q <= wr ? inc_wr : inc_rd;
      end
    end
  end

  dram_phase_seq #(.NUM_SEG(NUM_SEG), .TIME_W(TIME_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_ni),
    .go       (go),
    .t_row    (t_row),
    .t_col    (t_col),
    .t_data   (t_data),
    .t_pre    (t_pre),
    .phase    (phase),
    .capture  (capture),
    .step_end (step_end),
    .done     (done)
  );

  dram_addr_split #(.BASE_RW(BASE_RW), .SEL_W(SEL_W)) u_split (
    .width_sel (sel_q),
    .addr      (addr_q),
    .row       (row_a),
    .col       (col_a)
  );

  dram_seg_pack #(.SEG_W(SEG_W), .NUM_SEG(NUM_SEG)) u_pack (
    .clk     (clk),
    .rst_n   (rst_ni),
    .load    (go),
    .wdata   (wdata),
    .advance (step_end),
    .capture (capture && !wr_q),
    .dq_in   (dq_in),
    .seg_out (seg_out),
    .rdata   (rdata)
  );

  assign in_cas    = (phase == PH_COL) || (phase == PH_DATA);
  assign in_access = in_cas || (phase == PH_ROW);

  always_comb begin
    ma = '0;
    if (phase == PH_ROW) ma = row_a;
    else if (in_cas)     ma = col_a;
  end

  assign ras_n     = !in_access;
  assign cas_n     = !in_cas;
  assign dq_oe     = in_cas && wr_q;
  assign we_n      = !dq_oe;
  assign dq_out    = dq_oe ? seg_out : '0;
  assign busy      = (phase != PH_IDLE);
  assign next_base = addr_q;
endmodule

// File: rtl/dram_abs_chk.sv
module dram_abs_chk #(
  parameter int BASE_RW = 8,
  parameter int SEL_W   = 2,
  parameter int MA_W    = 11
) (
  input logic             clk,
  input logic             rst_ni,
  input logic             ras_n,
  input logic             cas_n,
  input logic             we_n,
  input logic             dq_oe,
  input logic             busy,
  input logic             done,
  input logic [SEL_W-1:0] sel_q,
  input logic [MA_W-1:0]  ma
);
  // R4: column strobe only inside an open row
  p_cas_in_row_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    !cas_n |-> !ras_n);
  // R2: column strobe falls only after a row-only cycle
  p_row_first_r2: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(cas_n) |-> $past(!ras_n && cas_n));
  // R4: row strobe rises only with the column strobe high as well
  p_full_precharge_r4: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(ras_n) |-> cas_n);
  // R6: write enable only during a column strobe with the bus driven
  p_we_in_cas_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    !we_n |-> (!cas_n && dq_oe));
  // R9: done only in an idle cycle
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    done |-> !busy);
  // R9: busy ends only with done
  p_busy_end_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(busy) |-> done);
  // R3: pins above the selected width stay low
  p_upper_pins_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (ma >> (BASE_RW + int'(sel_q))) == '0);
  // R1: strobes inactive while idle
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy |-> (ras_n && cas_n && we_n && !dq_oe));
endmodule

bind dram_abs_seq dram_abs_chk #(
  .BASE_RW (BASE_RW),
  .SEL_W   (SEL_W),
  .MA_W    (MA_W)
) u_chk (
  .clk    (clk),
  .rst_ni (rst_ni),
  .ras_n  (ras_n),
  .cas_n  (cas_n),
  .we_n   (we_n),
  .dq_oe  (dq_oe),
  .busy   (busy),
  .done   (done),
  .sel_q  (sel_q),
  .ma     (ma)
);

// File: tb/sim_dram_abs_seq.sv
`timescale 1ns/1ps
module sim_dram_abs_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  mode;
  logic        inc_rd, inc_wr, start, wr;
  logic [3:0]  t_row, t_col, t_data, t_pre;
  logic [21:0] base;
  logic [23:0] wdata;
  logic        busy, done, ras_n, cas_n, we_n, dq_oe;
  logic [23:0] rdata;
  logic [21:0] next_base;
  logic [10:0] ma;
  logic [7:0]  dq_out, dq_in;

  always #4 clk = ~clk;   // 125 MHz

  dram_abs_seq u0 (
    .clk(clk), .rst_n(rst_n), .mode(mode), .inc_rd(inc_rd), .inc_wr(inc_wr),
    .t_row(t_row), .t_col(t_col), .t_data(t_data), .t_pre(t_pre),
    .start(start), .wr(wr), .base(base), .wdata(wdata),
    .busy(busy), .done(done), .rdata(rdata), .next_base(next_base),
    .ma(ma), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  typedef struct packed {
    logic [10:0] ma;
    logic ras_n, cas_n, we_n, oe, busy, done;
    logic [7:0] dq;
  } exp_t;

  localparam exp_t IDLE_E = '{ma: '0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1,
                              oe: 1'b0, busy: 1'b0, done: 1'b0, dq: '0};

  exp_t        exp_q[$];
  logic [23:0] exp_rdata = '0;
  logic [21:0] exp_base  = '0;
  int          n_chk = 0;
  int          n_fail = 0;
  logic [10:0] row_lat = '0;

  function automatic logic [7:0] fmem(input int r, input int c);
    int v;
    v = r * 7 + c * 13 + 60;
    return v[7:0];
  endfunction

  task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", what, act, exp, $time);
    end
  endtask

  task automatic compare(input exp_t e);
    chk(ma == e.ma, "R2 R3 R10 ma", 32'(ma), 32'(e.ma));
    chk({ras_n, cas_n, we_n, dq_oe} == {e.ras_n, e.cas_n, e.we_n, e.oe},
        "R4 R5 strobes ras/cas/we/oe", 32'({ras_n, cas_n, we_n, dq_oe}),
        32'({e.ras_n, e.cas_n, e.we_n, e.oe}));
    chk({busy, done} == {e.busy, e.done}, "R9 busy/done",
        32'({busy, done}), 32'({e.busy, e.done}));
    if (e.oe) chk(dq_out == e.dq, "R6 write segment", 32'(dq_out), 32'(e.dq));
    if (e.done) begin
      chk(rdata == exp_rdata, "R7 packed read word", 32'(rdata), 32'(exp_rdata));
      chk(next_base == exp_base, "R8 next base", 32'(next_base), 32'(exp_base));
    end
  endtask

  // One clock: compare at the falling edge, then update the memory model.
  task automatic tick();
    exp_t e;
    @(negedge clk);
    if (exp_q.size() > 0) e = exp_q.pop_front();
    else                  e = IDLE_E;
    compare(e);
    if (!ras_n && cas_n) row_lat = ma;
    dq_in = (!cas_n) ? fmem(int'(row_lat), int'(ma)) : 8'h00;
  endtask

  task automatic push_word(input logic [3:0] m, input bit w, input logic [21:0] b,
                           input logic [23:0] wd, input int tr, input int tc,
                           input int td, input int tp, input bit inc);
    int rw, row, col, msk;
    logic [21:0] a;
    exp_t e;
    rw  = 8 + int'(m[1:0]);
    msk = (1 << rw) - 1;
    a   = b;
    for (int k = 0; k < 3; k++) begin
      row = int'(a) & msk;
      col = (int'(a) >> rw) & msk;
      e = '{ma: 11'(row), ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b1, oe: 1'b0,
            busy: 1'b1, done: 1'b0, dq: '0};
      for (int i = 0; i < (tr == 0 ? 1 : tr); i++) exp_q.push_back(e);
      e = '{ma: 11'(col), ras_n: 1'b0, cas_n: 1'b0, we_n: !w, oe: w,
            busy: 1'b1, done: 1'b0, dq: wd[8*k +: 8]};
      for (int i = 0; i < (tc == 0 ? 1 : tc) + (td == 0 ? 1 : td); i++) exp_q.push_back(e);
      if (!w) exp_rdata[8*k +: 8] = fmem(row, col);
      e = '{ma: '0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1, oe: 1'b0,
            busy: 1'b1, done: 1'b0, dq: '0};
      for (int i = 0; i < (tp == 0 ? 1 : tp); i++) exp_q.push_back(e);
      if (inc) a = a + 1'b1;
    end
    exp_base = a;
    e = IDLE_E;
    e.done = 1'b1;
    exp_q.push_back(e);
  endtask

  task automatic run_word(input logic [3:0] m, input bit w, input logic [21:0] b,
                          input logic [23:0] wd, input int tr, input int tc,
                          input int td, input int tp, input bit ir, input bit iw,
                          input bit disturb);
    int n;
    mode = m; wr = w; base = b; wdata = wd; inc_rd = ir; inc_wr = iw;
    t_row = 4'(tr); t_col = 4'(tc); t_data = 4'(td); t_pre = 4'(tp);
    push_word(m, w, b, wd, tr, tc, td, tp, w ? iw : ir);
    start = 1'b1;
    n = 0;
    while (exp_q.size() > 0) begin
      tick();
      start = 1'b0;
      n++;
      if (disturb && n == 4) begin
        // R9: all of these must be ignored while busy
        mode = 4'b1100; wr = !wr; base = ~base; wdata = ~wdata;
        inc_rd = !inc_rd; inc_wr = !inc_wr;
        t_row = 4'd9; t_col = 4'd7; t_data = 4'd5; t_pre = 4'd6;
        start = 1'b1;
      end
    end
    start = 1'b0;
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mode = 4'b0000; inc_rd = 1'b0; inc_wr = 1'b0; start = 1'b0;
    wr = 1'b0; t_row = 4'd1; t_col = 4'd1; t_data = 4'd1; t_pre = 4'd1;
    base = '0; wdata = '0; dq_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // Reset state: idle outputs (R1, R10)
    repeat (4) tick();
    chk(rdata == 24'h0, "R7 reset rdata", 32'(rdata), 32'h0);
    chk(next_base == 22'h0, "R8 reset next_base", 32'(next_base), 32'h0);

    // R2 R7 R8: 8-bit split, row carry into column
    run_word(4'b1100, 1'b0, 22'h0000FF, 24'h0, 1, 1, 1, 1, 1'b1, 1'b0, 1'b0);
    // R6 R5: 9-bit split write, mixed phase lengths
    run_word(4'b1101, 1'b1, 22'h01ABCD, 24'hA5C37E, 2, 1, 3, 1, 1'b0, 1'b1, 1'b0);
    // R5 R8: zero lengths count as one, increment disabled for reads
    run_word(4'b1110, 1'b0, 22'h0F0F3C, 24'h0, 0, 0, 0, 0, 1'b0, 1'b1, 1'b0);
    // R8: 11-bit split, wrap at the top of the address space
    run_word(4'b1111, 1'b1, 22'h3FFFFF, 24'h123456, 3, 2, 1, 2, 1'b0, 1'b1, 1'b0);
    // R3: high address bits must not reach the pins
    run_word(4'b1100, 1'b0, 22'h3F1234, 24'h0, 1, 2, 1, 1, 1'b1, 1'b1, 1'b0);
    // R9: start and input changes during a transfer are ignored
    run_word(4'b1111, 1'b0, 22'h2A55AA, 24'h0, 2, 1, 2, 3, 1'b1, 1'b0, 1'b1);
    run_word(4'b1110, 1'b1, 22'h155555, 24'hFEDCBA, 1, 3, 1, 1, 1'b0, 1'b0, 1'b1);

    // R1: modes with mode[3:2] != 2'b11 are not accepted
    for (int i = 0; i < 12; i++) begin
      mode = 4'(i); start = 1'b1;
      tick();
      start = 1'b0;
      repeat (2) tick();
      chk(busy == 1'b0, "R1 start ignored outside absolute mode", 32'(busy), 32'h0);
    end
    // R7: a read after a write still returns read data; write left rdata alone
    run_word(4'b1101, 1'b0, 22'h000200, 24'h0, 1, 1, 2, 1, 1'b1, 1'b0, 1'b0);
    repeat (3) tick();

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule